// File: doc/BRIEF.md
# Vectored Interrupt Flag Controller

This block arbitrates interrupts for a small 8-bit processor core. Each event input latches into a flag bit. A per-source mask bit and one global enable decide whether a latched flag may interrupt the core. While the global enable is set and at least one flag is both latched and unmasked, the block raises a vector request and presents the index of the winning source. The lowest source index has the highest priority.

When the core acknowledges the vector, the block clears the flag of the source being serviced and drops the global enable, which blocks every other source. A return-from-interrupt strobe sets the global enable again. Software can also set it directly, for example inside a handler to allow nesting. Flags that arrive while a source is masked, or while the global enable is clear, stay latched until they are serviced or software clears them.

A small register port lets software reach three registers. It can read the flags and clear them by writing ones. It can read and write the mask. It can read and write the global enable. Saving and restoring the core's status register is left to software.

Top module: `vecCtrl`

## Requirements
- R1: After reset all flags, all mask bits and the global enable are 0, vecReq is low, and every register address reads 0.
- R2: A high bit on evtIn in a clock cycle sets the matching flag at that edge, whatever the mask and global enable are. The flag then holds until it is cleared.
- R3: Reads are combinational from regAddr. Address 0 returns the flags, address 1 returns the mask, address 2 returns the global enable in bit 0 with bits 7..1 zero, and address 3 returns 0. A write to address 1 loads the mask. A write to address 2 loads bit 0 into the global enable. A write to address 3 changes nothing.
- R4: A write to address 0 clears every flag whose written bit is 1 and leaves the other flags unchanged.
- R5: If an event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R6: vecReq is high exactly when the global enable is 1 and (flags AND mask) is nonzero. vecIdx is then the lowest bit position set in (flags AND mask).
- R7: A vecAck in a cycle where vecReq is high clears the flag at vecIdx and the global enable at that edge, and vecReq is low in the next cycle. Other flags are not affected. A vecAck while vecReq is low has no effect.
- R8: A retiStb sets the global enable. If an accepted acknowledge happens in the same cycle, the acknowledge wins over retiStb, and retiStb wins over a software write to address 2.
- R9: A flag latched while its mask bit is 0 raises vecReq with its index as soon as the mask bit is set, provided the global enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | NUM_SRC (8) | Raw event inputs, one per source |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | DATA_W (8) | Register write data |
| regRdata | output | DATA_W (8) | Register read data |
| vecReq | output | 1 | Interrupt vector request to the core |
| vecIdx | output | IDX_W (3) | Index of the source being requested |
| vecAck | input | 1 | Core accepts the vector |
| retiStb | input | 1 | Return-from-interrupt strobe |

## Verification
A flag that drops or sticks in the wrong state shows up at the register port at address 0 on the cycle after the edge that should have changed it. The same fault also shows up on vecIdx as soon as that flag is the lowest one unmasked. A wrong global enable shows up the same cycle on vecReq, and also at address 2. A wrong priority choice appears on vecIdx with no delay, because the encoder is combinational. The bench sweeps every flag pattern against several masks, and walks a full service sequence through every source.

// File: rtl/vecCtrlPkg.sv
package vecCtrlPkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd2;

  typedef struct packed {
    logic takeVec;    // accepted acknowledge: clear winning flag
    logic flagClrWr;  // software write-one-to-clear on flags
    logic maskWr;     // software load of the mask register
  } dpStrobes_t;
endpackage

// File: rtl/vecDatapath.sv
module vecDatapath
  import vecCtrlPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  dpStrobes_t         stb,
  input  logic [DATA_W-1:0]  wData,
  input  logic [ADDR_W-1:0]  rAddr,
  input  logic               gie,
  output logic               anyPending,
  output logic [IDX_W-1:0]   winnerIdx,
  output logic [DATA_W-1:0]  rData
);
  logic [NUM_SRC-1:0] flagReg, maskReg, flagNext, pendVec, swClr, hwClr;

  assign pendVec = flagReg & maskReg;
  assign swClr   = stb.flagClrWr ? wData[NUM_SRC-1:0] : '0;
  assign hwClr   = stb.takeVec ? (NUM_SRC'(1) << winnerIdx) : '0;

  // Per-source flag update: a set in the same cycle beats any clear.
  for (genvar g = 0; g < NUM_SRC; g++) begin : gFlag
    assign flagNext[g] = evtIn[g] | (flagReg[g] & ~swClr[g] & ~hwClr[g]);

    p_evt_sets_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
      evtIn[g] |=> flagReg[g]);
    p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!flagReg[g] && !evtIn[g]) |=> !flagReg[g]);
    p_set_beats_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
      (evtIn[g] && stb.flagClrWr && wData[g]) |=> flagReg[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg <= '0;
      maskReg <= '0;
    end else begin
      flagReg <= flagNext;
      if (stb.maskWr) maskReg <= wData[NUM_SRC-1:0];
    end
  end

  // Fixed priority: the lowest index wins.
  always_comb begin
    winnerIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendVec[i]) winnerIdx = IDX_W'(i);
    end
  end
  assign anyPending = |pendVec;

  always_comb begin
    unique case (rAddr)
      ADDR_FLAGS: rData = DATA_W'(flagReg);
      ADDR_MASK:  rData = DATA_W'(maskReg);
      ADDR_CTRL:  rData = DATA_W'(gie);
      default:    rData = '0;
    endcase
  end

  p_winner_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    anyPending |-> (flagReg[winnerIdx] && maskReg[winnerIdx]));
  p_take_clears_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeVec && !evtIn[winnerIdx]) |=> !flagReg[$past(winnerIdx)]);
endmodule

// File: rtl/vecControl.sv
module vecControl
  import vecCtrlPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              anyPending,
  input  logic              vecAck,
  input  logic              retiStb,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wData,
  output logic              gie,
  output logic              vecReq,
  output dpStrobes_t        stb
);
  logic ctrlWr;

  assign vecReq        = gie & anyPending;
  assign stb.takeVec   = vecReq & vecAck;
  assign stb.flagClrWr = regWe && (regAddr == ADDR_FLAGS);
  assign stb.maskWr    = regWe && (regAddr == ADDR_MASK);
  assign ctrlWr        = regWe && (regAddr == ADDR_CTRL);

  // Global enable: accepted acknowledge > return strobe > software write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              gie <= 1'b0;
    else if (stb.takeVec)   gie <= 1'b0;
    else if (retiStb)       gie <= 1'b1;
    else if (ctrlWr)        gie <= wData[0];
  end

  p_ack_drops_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    (vecReq && vecAck) |=> (!vecReq && !gie));
  p_reti_sets_gie_r8: assert property (@(posedge clk) disable iff (!rstN)
    (retiStb && !(vecReq && vecAck)) |=> gie);
  p_gie_rise_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gie) |-> $past(retiStb || (regWe && regAddr == ADDR_CTRL && wData[0])));
endmodule

// File: rtl/vecCtrl.sv
module vecCtrl
  import vecCtrlPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               vecReq,
  output logic [IDX_W-1:0]   vecIdx,
  input  logic               vecAck,
  input  logic               retiStb
);
  dpStrobes_t stb;
  logic       gie, anyPending;

  vecControl #(.DATA_W(DATA_W)) uCtl (
    .clk(clk), .rstN(rstN), .anyPending(anyPending), .vecAck(vecAck),
    .retiStb(retiStb), .regWe(regWe), .regAddr(regAddr), .wData(regWdata),
    .gie(gie), .vecReq(vecReq), .stb(stb)
  );

  vecDatapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .stb(stb), .wData(regWdata),
    .rAddr(regAddr), .gie(gie), .anyPending(anyPending),
    .winnerIdx(vecIdx), .rData(regRdata)
  );
endmodule

// File: tb/sim_vecCtrl.sv
`timescale 1ns/1ps
module sim_vecCtrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] evtIn = '0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       vecReq;
  logic [2:0] vecIdx;
  logic       vecAck = 1'b0;
  logic       retiStb = 1'b0;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  vecCtrl u0 (.clk(clk), .rstN(rstN), .evtIn(evtIn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .vecReq(vecReq), .vecIdx(vecIdx), .vecAck(vecAck), .retiStb(retiStb));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    regWe = 0; evtIn = '0; vecAck = 0; retiStb = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWe = 1; regAddr = a; regWdata = d; step();
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a; #0.5; d = regRdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] masks [4] = '{8'hFF, 8'hA5, 8'h0F, 8'h30};
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    check("R1 vecReq", vecReq, 0);
    for (int a = 0; a < 4; a++) begin rd(2'(a), r); check("R1 read", r, 0); end

    // R3 register map
    wr(2'd1, 8'h5A); rd(2'd1, r); check("R3 mask readback", r, 8'h5A);
    wr(2'd2, 8'h01); rd(2'd2, r); check("R3 gie set", r, 1);
    wr(2'd2, 8'hFE); rd(2'd2, r); check("R3 gie only bit0", r, 0);
    wr(2'd3, 8'hFF); rd(2'd3, r); check("R3 addr3 reads 0", r, 0);
    rd(2'd1, r); check("R3 addr3 write no effect", r, 8'h5A);

    // R2 latching while masked and globally disabled
    wr(2'd1, 8'h00);
    evtIn = 8'h81; step();
    rd(2'd0, r); check("R2 flags set", r, 8'h81);
    check("R2 no req while disabled", vecReq, 0);
    step(); rd(2'd0, r); check("R2 flags held", r, 8'h81);

    // R4 write-one-to-clear
    wr(2'd0, 8'h01); rd(2'd0, r); check("R4 w1c partial", r, 8'h80);
    wr(2'd0, 8'hFF);
    // R5 set wins over clear
    evtIn = 8'h10; step();
    evtIn = 8'h04; regWe = 1; regAddr = 2'd0; regWdata = 8'h14; step();
    rd(2'd0, r); check("R5 set beats clear", r, 8'h04);

    // R9 masked flag released by mask
    wr(2'd2, 8'h01);
    check("R9 masked no req", vecReq, 0);
    wr(2'd1, 8'h04);
    check("R9 req after unmask", vecReq, 1);
    check("R9 idx after unmask", vecIdx, 2);

    // R6 exhaustive flag sweep against several masks
    for (int mi = 0; mi < 4; mi++) begin
      for (int f = 0; f < 256; f++) begin
        int expIdx;
        logic [7:0] pend;
        wr(2'd0, 8'hFF);
        wr(2'd1, masks[mi]);
        evtIn = 8'(f); step();
        pend = 8'(f) & masks[mi];
        expIdx = 0;
        for (int b = 7; b >= 0; b--) if (pend[b]) expIdx = b;
        check("R6 req", vecReq, (pend != 0) ? 1 : 0);
        if (pend != 0) check("R6 idx", vecIdx, expIdx);
      end
    end
    wr(2'd2, 8'h00);
    check("R6 req low with gie clear", vecReq, 0);

    // R7/R8 service walk through all sources
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    evtIn = 8'hFF; step();
    wr(2'd2, 8'h01);
    for (int k = 0; k < 8; k++) begin
      check("R7 req before ack", vecReq, 1);
      check("R7 idx order", vecIdx, k);
      vecAck = 1; step();
      check("R7 req low after ack", vecReq, 0);
      rd(2'd0, r); check("R7 flag cleared", r, 8'(8'hFF << (k + 1)));
      rd(2'd2, r); check("R7 gie cleared", r, 0);
      retiStb = 1; step();
      rd(2'd2, r); check("R8 reti sets gie", r, 1);
    end

    // R7 ack without request has no effect
    wr(2'd2, 8'h00);
    evtIn = 8'h08; step();
    vecAck = 1; step();
    rd(2'd0, r); check("R7 stray ack ignored", r, 8'h08);
    // R8 ack beats reti and software write
    wr(2'd2, 8'h01);
    vecAck = 1; retiStb = 1; step();
    rd(2'd2, r); check("R8 ack beats reti", r, 0);
    rd(2'd0, r); check("R8 ack still clears", r, 8'h00);
    evtIn = 8'h02; step();
    wr(2'd2, 8'h01);
    vecAck = 1; regWe = 1; regAddr = 2'd2; regWdata = 8'h01; step();
    rd(2'd2, r); check("R8 ack beats write", r, 0);
    // R8 reti beats software clear of gie
    retiStb = 1; regWe = 1; regAddr = 2'd2; regWdata = 8'h00; step();
    rd(2'd2, r); check("R8 reti beats write", r, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule